// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block keeps one precision-time snapshot for each traffic direction. An upstream classifier has already matched a time-sync event packet. It raises a one-cycle capture strobe together with the packet's 16-bit sequence identifier. The latch then copies the free-running 64-bit time value and the sequence identifier into that direction's holding registers. It raises a valid flag, and from then on it refuses further captures. Software reads the held time through two 32-bit words. It then writes a 1 to the valid bit, which empties the channel and arms it again.

Each direction is a small two-state machine. In `CAP_ARMED` the channel waits for a strobe. The *capture* transition goes to `CAP_HELD` when the strobe arrives, the direction's 3-bit enable field is non-zero, and no clear is requested in that cycle. In `CAP_HELD` the channel ignores strobes. The *release* transition goes back to `CAP_ARMED` when a clear is requested, and it empties the holding registers. A clear is requested either by a write-one to the valid bit, or, for the receive channel only, by a write to either enable register. Rewriting the capture configuration therefore throws away any stale receive timestamp.

Registers are word-addressed: 0 receive status, 1 receive time low, 2 receive time high, 3 transmit status, 4 transmit time low, 5 transmit time high, 6 receive enable, 7 transmit enable. Reads are combinational from `reg_addr`. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset every register reads 0: both channels are in `CAP_ARMED`, and both enable fields are 0.
- R2: In `CAP_ARMED` with a non-zero enable field, a strobe at a clock edge has a visible effect from the next cycle. Status bit 16 reads 1 and status bits 15:0 read the strobe's sequence identifier. The low and high time words read bits 31:0 and 63:32 of the time value present at that edge.
- R3: In `CAP_HELD`, further strobes change neither the status word nor the time words.
- R4: A status write with bit 16 set returns the channel to `CAP_ARMED`, so a later strobe is captured again. A status write with bit 16 clear has no effect.
- R5: With the direction's enable field equal to 0, strobes leave the channel in `CAP_ARMED` and its status reads 0.
- R6: The two channels are independent. A strobe, clear or status write on one channel does not change the other channel's registers.
- R7: A write to either enable register releases the receive channel. The transmit channel is not affected by enable writes.
- R8: When a strobe and a clear request fall in the same cycle, the clear wins. The strobe is dropped and the status reads 0 afterwards, whether the channel was armed or held.
- R9: The release transition sets the sequence identifier and both time words to 0. Status bits 31:17 always read 0.
- R10: An enable register stores write bits 2:0 and reads them back in bits 2:0. Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running time value to snapshot |
| rx_cap | input | 1 | Receive capture strobe from the classifier |
| rx_seq | input | 16 | Receive packet sequence identifier |
| tx_cap | input | 1 | Transmit capture strobe from the classifier |
| tx_seq | input | 16 | Transmit packet sequence identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
A capture strobe and a clear request can land in the same clock cycle. The clear can be a write-one to the status bit or, for the receive channel, a rewrite of an enable field. The bench drives the strobe and the register write in the same cycle, once with the channel armed and once with it already holding a value. It then reads the status and time words one cycle later and expects all zeros in both cases: the clear took effect and the strobe left no trace.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
    localparam int NUM_CH      = 2;   // channel 0 receive, channel 1 transmit
    localparam int ADDR_W      = 3;
    localparam int REG_W       = 32;
    localparam int TS_W        = 2 * REG_W;
    localparam int SEQ_W       = 16;
    localparam int EN_W        = 3;
    localparam int VALID_BIT   = SEQ_W;
    localparam int REGS_PER_CH = 3;   // status, time low, time high
    localparam int EN_BASE     = REGS_PER_CH * NUM_CH;
    localparam int CFG_CLR_CH  = 0;   // channel released by enable rewrites

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/tscap_channel.sv
module tscap_channel
    import tscap_pkg::*;
#(
    parameter int TSW = TS_W,
    parameter int SQW = SEQ_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_any,
    input  logic           cap_pulse,
    input  logic [SQW-1:0] seq_in,
    input  logic [TSW-1:0] time_in,
    input  logic           clr,
    output logic           valid,
    output logic [SQW-1:0] seq_q,
    output logic [TSW-1:0] ts_q
);
    cap_state_e state_q, state_d;
    logic       take;

    // next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                if (!clr && cap_pulse && en_any) begin
                    state_d = CAP_HELD;   // capture
                    take    = 1'b1;
                end
            end
            CAP_HELD: begin
                if (clr) begin
                    state_d = CAP_ARMED;  // release
                end
            end
            default: state_d = CAP_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // output (holding) registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
            ts_q  <= '0;
        end else if (take) begin
            seq_q <= seq_in;
            ts_q  <= time_in;
        end else if (clr) begin
            seq_q <= '0;
            ts_q  <= '0;
        end
    end

    assign valid = (state_q == CAP_HELD);
endmodule

// File: rtl/tscap_regfile.sv
module tscap_regfile
    import tscap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NUM_CH-1:0]             ch_valid,
    input  logic [NUM_CH-1:0][SEQ_W-1:0]  ch_seq,
    input  logic [NUM_CH-1:0][TS_W-1:0]   ch_ts,
    output logic [NUM_CH-1:0]             ch_clr,
    output logic [NUM_CH-1:0]             ch_en_any
);
    logic [NUM_CH-1:0][EN_W-1:0] en_q;
    logic [NUM_CH-1:0]           en_hit;
    logic [NUM_CH-1:0]           w1c_hit;
    logic                        cfg_write;
    logic                        unused_wdata_bits;

    assign unused_wdata_bits = ^{reg_wdata[REG_W-1:VALID_BIT+1],
                                 reg_wdata[VALID_BIT-1:EN_W]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign en_hit[c]  = reg_wr && (reg_addr == ADDR_W'(EN_BASE + c));
        assign w1c_hit[c] = reg_wr && (reg_addr == ADDR_W'(REGS_PER_CH * c))
                            && reg_wdata[VALID_BIT];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[c] <= '0;
            end else if (en_hit[c]) begin
                en_q[c] <= reg_wdata[EN_W-1:0];
            end
        end

        assign ch_en_any[c] = |en_q[c];

        if (c == CFG_CLR_CH) begin : g_cfg
            assign ch_clr[c] = w1c_hit[c] | cfg_write;
        end else begin : g_plain
            assign ch_clr[c] = w1c_hit[c];
        end
    end

    assign cfg_write = |en_hit;

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(REGS_PER_CH * c)) begin
                reg_rdata = REG_W'({ch_valid[c], ch_seq[c]});
            end
            if (reg_addr == ADDR_W'(REGS_PER_CH * c + 1)) begin
                reg_rdata = ch_ts[c][REG_W-1:0];
            end
            if (reg_addr == ADDR_W'(REGS_PER_CH * c + 2)) begin
                reg_rdata = ch_ts[c][TS_W-1:REG_W];
            end
            if (reg_addr == ADDR_W'(EN_BASE + c)) begin
                reg_rdata = REG_W'(en_q[c]);
            end
        end
    end
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
    import tscap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_now,
    input  logic              rx_cap,
    input  logic [SEQ_W-1:0]  rx_seq,
    input  logic              tx_cap,
    input  logic [SEQ_W-1:0]  tx_seq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [NUM_CH-1:0]            ch_pulse;
    logic [NUM_CH-1:0][SEQ_W-1:0] ch_seq_in;
    logic [NUM_CH-1:0]            ch_valid;
    logic [NUM_CH-1:0][SEQ_W-1:0] ch_seq;
    logic [NUM_CH-1:0][TS_W-1:0]  ch_ts;
    logic [NUM_CH-1:0]            ch_clr;
    logic [NUM_CH-1:0]            ch_en_any;

    assign ch_pulse  = {tx_cap, rx_cap};
    assign ch_seq_in = {tx_seq, rx_seq};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tscap_channel #(.TSW(TS_W), .SQW(SEQ_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_any    (ch_en_any[c]),
            .cap_pulse (ch_pulse[c]),
            .seq_in    (ch_seq_in[c]),
            .time_in   (time_now),
            .clr       (ch_clr[c]),
            .valid     (ch_valid[c]),
            .seq_q     (ch_seq[c]),
            .ts_q      (ch_ts[c])
        );
    end

    tscap_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ch_valid  (ch_valid),
        .ch_seq    (ch_seq),
        .ch_ts     (ch_ts),
        .ch_clr    (ch_clr),
        .ch_en_any (ch_en_any)
    );
endmodule

// File: rtl/tscap_checker.sv
module tscap_checker
    import tscap_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [TS_W-1:0]               time_now,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [NUM_CH-1:0]             ch_pulse,
    input logic [NUM_CH-1:0]             ch_clr,
    input logic [NUM_CH-1:0]             ch_en_any,
    input logic [NUM_CH-1:0]             ch_valid,
    input logic [NUM_CH-1:0][TS_W-1:0]   ch_ts
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: an armed, enabled channel snapshots the time on a strobe
        p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_valid[c] && ch_en_any[c] && ch_pulse[c] && !ch_clr[c])
            |=> (ch_valid[c] && ch_ts[c] == $past(time_now)));

        // R3: a held value is kept until a clear
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_valid[c] && !ch_clr[c]) |=> (ch_valid[c] && $stable(ch_ts[c])));

        // R4 / R9: a clear always empties the channel
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_clr[c] |=> (!ch_valid[c] && ch_ts[c] == '0));

        // R5: no capture without strobe and enable
        p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_valid[c] && !(ch_pulse[c] && ch_en_any[c])) |=> !ch_valid[c]);

        // R8: strobe together with clear leaves nothing held
        p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pulse[c] && ch_clr[c]) |=> !ch_valid[c]);
    end

    // R7: any enable rewrite releases the receive channel
    p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= ADDR_W'(EN_BASE)) |=> !ch_valid[CFG_CLR_CH]);
endmodule

bind ts_capture_latch tscap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_now  (time_now),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ch_pulse  (ch_pulse),
    .ch_clr    (ch_clr),
    .ch_en_any (ch_en_any),
    .ch_valid  (ch_valid),
    .ch_ts     (ch_ts)
);

// File: tb/ts_capture_latch_tb.sv
module ts_capture_latch_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_RXS = 3'd0, A_RXL = 3'd1, A_RXH = 3'd2;
    localparam logic [2:0] A_TXS = 3'd3, A_TXL = 3'd4, A_TXH = 3'd5;
    localparam logic [2:0] A_RXE = 3'd6, A_TXE = 3'd7;
    localparam logic [31:0] W1C = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        rx_cap = 1'b0, tx_cap = 1'b0;
    logic [15:0] rx_seq = '0, tx_seq = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    int          n_checks = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_capture_latch u_dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .rx_cap(rx_cap), .rx_seq(rx_seq), .tx_cap(tx_cap), .tx_seq(tx_seq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // optional strobe with optional same-cycle register write
    task automatic strobe(input bit is_tx, input logic [15:0] seq, input logic [63:0] t,
                          input bit do_wr, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        time_now = t;
        if (is_tx) begin tx_cap = 1'b1; tx_seq = seq; end
        else begin rx_cap = 1'b1; rx_seq = seq; end
        if (do_wr) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
        @(negedge clk);
        rx_cap = 1'b0; tx_cap = 1'b0; reg_wr = 1'b0;
        time_now = t + 64'd1000;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset", 3'(a), 32'h0);
    endtask

    task automatic t_disabled();
        strobe(0, 16'h0042, 64'h11, 0, 0, 0);
        rd_chk("R5 rx disabled", A_RXS, 32'h0);
        strobe(1, 16'h0043, 64'h12, 0, 0, 0);
        rd_chk("R5 tx disabled", A_TXS, 32'h0);
    endtask

    task automatic t_enable_rw();
        wr(A_RXE, 32'hFFFF_FFFD);
        rd_chk("R10 rx enable readback", A_RXE, 32'h5);
        wr(A_TXE, 32'h0000_0002);
        rd_chk("R10 tx enable readback", A_TXE, 32'h2);
    endtask

    task automatic t_capture_hold();
        strobe(0, 16'h1234, 64'h0123_4567_89AB_CDEF, 0, 0, 0);
        rd_chk("R2 rx status", A_RXS, 32'h0001_1234);
        rd_chk("R2 rx low", A_RXL, 32'h89AB_CDEF);
        rd_chk("R2 rx high", A_RXH, 32'h0123_4567);
        rd_chk("R6 tx untouched", A_TXS, 32'h0);
        strobe(0, 16'h5555, 64'hFFFF_0000_FFFF_0000, 0, 0, 0);
        rd_chk("R3 status held", A_RXS, 32'h0001_1234);
        rd_chk("R3 low held", A_RXL, 32'h89AB_CDEF);
        rd_chk("R3 high held", A_RXH, 32'h0123_4567);
    endtask

    task automatic t_clear();
        wr(A_RXS, 32'hFFFE_FFFF);
        rd_chk("R4 bit16 clear write ignored", A_RXS, 32'h0001_1234);
        wr(A_TXS, W1C);
        rd_chk("R6 tx clear leaves rx", A_RXS, 32'h0001_1234);
        wr(A_RXS, W1C);
        rd_chk("R9 status after release", A_RXS, 32'h0);
        rd_chk("R9 low after release", A_RXL, 32'h0);
        rd_chk("R9 high after release", A_RXH, 32'h0);
        strobe(0, 16'hBEEF, 64'hDEAD_0000_0000_0007, 0, 0, 0);
        rd_chk("R4 recapture status", A_RXS, 32'h0001_BEEF);
        rd_chk("R4 recapture high", A_RXH, 32'hDEAD_0000);
    endtask

    task automatic t_tx_and_cfg();
        strobe(1, 16'hA5A5, 64'h0000_0009_0000_0077, 0, 0, 0);
        rd_chk("R2 tx status", A_TXS, 32'h0001_A5A5);
        rd_chk("R2 tx low", A_TXL, 32'h0000_0077);
        rd_chk("R6 rx still held", A_RXS, 32'h0001_BEEF);
        wr(A_TXE, 32'h1);
        rd_chk("R7 tx enable write releases rx", A_RXS, 32'h0);
        rd_chk("R7 tx channel kept", A_TXS, 32'h0001_A5A5);
        strobe(0, 16'h0101, 64'h5, 0, 0, 0);
        rd_chk("R2 rx capture again", A_RXS, 32'h0001_0101);
        wr(A_RXE, 32'h7);
        rd_chk("R7 rx enable write releases rx", A_RXS, 32'h0);
        rd_chk("R7 tx channel still kept", A_TXS, 32'h0001_A5A5);
    endtask

    task automatic t_race();
        // armed rx, strobe with same-cycle W1C
        strobe(0, 16'h0777, 64'h0000_0000_0000_0777, 1, A_RXS, W1C);
        rd_chk("R8 armed strobe+clear status", A_RXS, 32'h0);
        rd_chk("R8 armed strobe+clear low", A_RXL, 32'h0);
        // held tx, strobe with same-cycle W1C
        strobe(1, 16'h0888, 64'h888, 1, A_TXS, W1C);
        rd_chk("R8 held strobe+clear status", A_TXS, 32'h0);
        rd_chk("R8 held strobe+clear low", A_TXL, 32'h0);
        // armed rx, strobe with same-cycle enable rewrite
        strobe(0, 16'h0999, 64'h999, 1, A_RXE, 32'h7);
        rd_chk("R8 strobe+config write", A_RXS, 32'h0);
        strobe(1, 16'h0AAA, 64'hAAA, 0, 0, 0);
        rd_chk("R2 tx after race", A_TXS, 32'h0001_0AAA);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_enable_rw();
        t_capture_hold();
        t_clear();
        t_tx_and_cfg();
        t_race();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule